// File: doc/BRIEF.md
# Translation and Exception Control Register Block

This block keeps the control state that an address-translation unit and its exception logic need: the translation control word, the two halves of the page-table entry staged for software refills, an entry-assistance field, the table base, the faulting virtual address and three event/trap code registers. Every write passes through a per-register field mask, so truncated fields always read back with their upper bits cleared. Two side effects leave the block as one-cycle strobes. Setting the invalidate bit in the control word requests that every TLB entry be discarded, and that bit is never stored. Writing a new address-space identifier into the entry-high register requests a TLB flush, and that happens only when the identifier really changes.

A second address space, the array window, gives software direct access to cache and TLB arrays. Three address bits pick one of eight regions. The four TLB regions are routed to a select bus that a neighbouring TLB array decodes. The four cache regions behave as empty arrays. Three constant identification registers report the processor version, the cache version and the processor revision.

Every request is answered one cycle later with a response that carries read data or an error flag. A request that is answered with an error changes nothing.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every stored register reads 0, and `rsp_valid`, `rsp_err`, `tlb_inval`, `tlb_flush` and `arr_sel` are all 0.
- R2: A legal write to the control word (offset 0x00) with bit 2 set pulses `tlb_inval` in the cycle after the write. Bit 2 always reads back as 0, and the other 31 bits are stored as written. A write with bit 2 clear gives no pulse.
- R3: A legal write to entry-high (offset 0x04) stores all 32 bits. It pulses `tlb_flush` in the next cycle exactly when written bits 7:0 differ from the stored bits 7:0.
- R4: Entry-assistance (0x0C) keeps only bits 3:0. Trap code (0x20), exception event (0x24) and interrupt event (0x28) keep only bits 10:0. The other bits read as 0.
- R5: Entry-low (0x08), table base (0x10) and fault address (0x14) store all 32 bits.
- R6: Reads at offsets 0x30, 0x40 and 0x44 return the parameters `PROC_VER`, `CACHE_VER` and `PROC_REV`. A write to any of them is an error.
- R7: In the array window (`req_win`=1), address bits 26:24 select the region. Region 2 drives `arr_sel[0]`, 3 drives `arr_sel[1]`, 6 drives `arr_sel[2]` and 7 drives `arr_sel[3]`, combinationally in the request cycle, together with `arr_we` for writes and `arr_addr` = address bits 23:0. A TLB-region read returns `arr_rdata`.
- R8: Regions 0, 1, 4 and 5 (cache address/data) read as 0, accept writes without effect and never assert `arr_sel` or `arr_we`.
- R9: Only word accesses (`req_size`=2; 0 is byte, 1 is half, 3 is reserved) are legal. Any other size answers with an error, asserts no array select and changes no register.
- R10: A control-space access to an offset that is not listed above is an error. An errored write changes no register and pulses no strobe.
- R11: Each accepted request produces `rsp_valid` for exactly the following cycle. `rsp_err` is set only on errors, and `rsp_rdata` is 0 for writes and errors.
- R12: Each qualifying write produces a strobe that is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 1 = array window, 0 = control registers |
| req_addr | input | ADDR_W (27) | Byte address; offset in bits 7:0 for control space |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Read data |
| tlb_inval | output | 1 | Invalidate-all strobe |
| tlb_flush | output | 1 | Flush strobe after an identifier change |
| arr_sel | output | 4 | One-hot select of the TLB array ports |
| arr_we | output | 1 | Write enable to the selected array port |
| arr_addr | output | REGION_LSB (24) | Offset inside the selected region |
| arr_wdata | output | 32 | Write data to the array port |
| arr_rdata | input | 32 | Read data from the selected array port, same cycle |

## Verification
The hardest situation to reach from the ports is the flush decision. It depends on the identifier already stored, so the same write pulses or stays silent depending on history. The stimulus therefore walks entry-high through a sequence that alternates between repeated and changed identifiers, with changes confined to the upper 24 bits in between. A sub-word write that carries a new identifier is mixed in to show that a rejected access neither flushes nor moves the stored value. Separately, every combination of region, size and direction in the array window is swept against an array model that answers with data derived from the select and offset.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
   localparam int DATA_W = 32;
   localparam int NREG   = 9;
   localparam int OFF_W  = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      RI_CTRL     = 4'd0,
      RI_PTE_HI   = 4'd1,
      RI_PTE_LO   = 4'd2,
      RI_PTE_AUX  = 4'd3,
      RI_TBL_BASE = 4'd4,
      RI_FAULT_VA = 4'd5,
      RI_TRAP     = 4'd6,
      RI_EXC_EVT  = 4'd7,
      RI_IRQ_EVT  = 4'd8
   } reg_idx_e;

   localparam logic [OFF_W-1:0] OFF_PVER = 8'h30;
   localparam logic [OFF_W-1:0] OFF_CVER = 8'h40;
   localparam logic [OFF_W-1:0] OFF_PREV = 8'h44;

   function automatic logic [OFF_W-1:0] reg_offset(input int idx);
      case (idx)
         0:       return 8'h00;
         1:       return 8'h04;
         2:       return 8'h08;
         3:       return 8'h0C;
         4:       return 8'h10;
         5:       return 8'h14;
         6:       return 8'h20;
         7:       return 8'h24;
         default: return 8'h28;
      endcase
   endfunction
endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
   import mmu_ctl_pkg::*;
#(
   parameter logic [31:0] PROC_VER  = 32'h0,
   parameter logic [31:0] CACHE_VER = 32'h0,
   parameter logic [31:0] PROC_REV  = 32'h0
) (
   input  logic [OFF_W-1:0]  off,
   output logic              hit,
   output logic              ro,
   output logic [3:0]        idx,
   output logic [DATA_W-1:0] ro_data
);
   always_comb begin
      hit     = 1'b0;
      ro      = 1'b0;
      idx     = '0;
      ro_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (off == reg_offset(i)) begin
            hit = 1'b1;
            idx = 4'(i);
         end
      end
      case (off)
         OFF_PVER: begin hit = 1'b1; ro = 1'b1; ro_data = PROC_VER;  end
         OFF_CVER: begin hit = 1'b1; ro = 1'b1; ro_data = CACHE_VER; end
         OFF_PREV: begin hit = 1'b1; ro = 1'b1; ro_data = PROC_REV;  end
         default: ;
      endcase
   end
endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
   import mmu_ctl_pkg::*;
#(
   parameter int TI_BIT = 2,
   parameter int ASID_W = 8,
   parameter int AUX_W  = 4,
   parameter int EVT_W  = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [3:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              inval_q,
   output logic              flush_q
);
   localparam int FLAT_W = NREG * DATA_W;

   if (TI_BIT < 0 || TI_BIT >= DATA_W) begin : g_bad_ti
      $error("TI_BIT outside the data word");
   end
   if (ASID_W < 1 || ASID_W > DATA_W) begin : g_bad_asid
      $error("ASID_W outside 1..DATA_W");
   end
   if (AUX_W < 1 || AUX_W > DATA_W || EVT_W < 1 || EVT_W > DATA_W) begin : g_bad_fields
      $error("field width outside 1..DATA_W");
   end

   function automatic logic [DATA_W-1:0] field_mask(input int i);
      logic [DATA_W-1:0] ones;
      ones = '1;
      case (i)
         int'(RI_CTRL):    return ~(DATA_W'(1) << TI_BIT);
         int'(RI_PTE_AUX): return ones >> (DATA_W - AUX_W);
         int'(RI_TRAP),
         int'(RI_EXC_EVT),
         int'(RI_IRQ_EVT): return ones >> (DATA_W - EVT_W);
         default:          return ones;
      endcase
   endfunction

   logic [FLAT_W-1:0] reg_flat;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = field_mask(i);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (wr_en && wr_idx == 4'(i)) begin
            q <= wr_data & MASK;
         end
      end
      assign reg_flat[i*DATA_W +: DATA_W] = q;
   end

   logic [ASID_W-1:0] asid_now;
   assign asid_now = reg_flat[int'(RI_PTE_HI)*DATA_W +: ASID_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         inval_q <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         inval_q <= wr_en && (wr_idx == RI_CTRL) && wr_data[TI_BIT];
         flush_q <= wr_en && (wr_idx == RI_PTE_HI) &&
                    (wr_data[ASID_W-1:0] != asid_now);
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == 4'(i)) rd_data = reg_flat[i*DATA_W +: DATA_W];
      end
   end

   assert_flush_on_asid_change_R3: assert property (@(posedge clk) disable iff (rst)
      flush_q |-> (asid_now != $past(asid_now)));

   assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(reg_flat));

   assert_inval_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
      (inval_q && !$past(wr_en)) |-> 1'b0);
endmodule

// File: rtl/mmu_ctl_window.sv
module mmu_ctl_window
   import mmu_ctl_pkg::*;
#(
   parameter int ADDR_W     = 27,
   parameter int REGION_LSB = 24
) (
   input  logic                  valid,
   input  logic                  write,
   input  logic                  win,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [1:0]            size,
   output logic [3:0]            arr_sel,
   output logic                  arr_we,
   output logic [REGION_LSB-1:0] arr_addr,
   output logic                  is_tlb,
   output logic                  size_err
);
   localparam int NPORT = 4;

   logic [2:0] region;
   logic       word_ok;

   assign region   = addr[REGION_LSB +: 3];
   assign word_ok  = (size == SZ_WORD);
   assign size_err = valid && win && !word_ok;
   assign is_tlb   = region[1];
   assign arr_addr = addr[REGION_LSB-1:0];

   for (genvar k = 0; k < NPORT; k++) begin : g_port
      localparam logic [2:0] RG = 3'((k / 2) * 4 + 2 + (k % 2));
      assign arr_sel[k] = valid && win && word_ok && (region == RG);
   end

   assign arr_we = write && (|arr_sel);

   always_comb begin
      assert_sel_onehot_R7: assert ($onehot0(arr_sel));
      assert_sel_word_only_R9: assert (!(|arr_sel) || size == SZ_WORD);
      assert_cache_no_sel_R8: assert (region[1] || !(|arr_sel));
   end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
   import mmu_ctl_pkg::*;
#(
   parameter int          ADDR_W     = 27,
   parameter int          REGION_LSB = 24,
   parameter int          TI_BIT     = 2,
   parameter int          ASID_W     = 8,
   parameter int          AUX_W      = 4,
   parameter int          EVT_W      = 11,
   parameter logic [31:0] PROC_VER   = 32'h0400_0000,
   parameter logic [31:0] CACHE_VER  = 32'h2000_0000,
   parameter logic [31:0] PROC_REV   = 32'h0000_0001
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic                  req_win,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [1:0]            req_size,
   input  logic [31:0]           req_wdata,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [31:0]           rsp_rdata,
   output logic                  tlb_inval,
   output logic                  tlb_flush,
   output logic [3:0]            arr_sel,
   output logic                  arr_we,
   output logic [REGION_LSB-1:0] arr_addr,
   output logic [31:0]           arr_wdata,
   input  logic [31:0]           arr_rdata
);
   if (REGION_LSB < OFF_W) begin : g_bad_lsb
      $error("REGION_LSB must cover the control offset");
   end
   if (ADDR_W < REGION_LSB + 3) begin : g_bad_aw
      $error("ADDR_W too small for the region field");
   end

   logic              dec_hit, dec_ro;
   logic [3:0]        dec_idx;
   logic [31:0]       dec_ro_data;
   logic [31:0]       rf_rdata;
   logic              win_is_tlb, win_size_err;
   logic              ctl_err, req_err, reg_wr;
   logic [31:0]       rdata_nxt;

   mmu_ctl_decode #(
      .PROC_VER (PROC_VER),
      .CACHE_VER(CACHE_VER),
      .PROC_REV (PROC_REV)
   ) u_decode (
      .off    (req_addr[OFF_W-1:0]),
      .hit    (dec_hit),
      .ro     (dec_ro),
      .idx    (dec_idx),
      .ro_data(dec_ro_data)
   );

   mmu_ctl_window #(
      .ADDR_W    (ADDR_W),
      .REGION_LSB(REGION_LSB)
   ) u_window (
      .valid   (req_valid),
      .write   (req_write),
      .win     (req_win),
      .addr    (req_addr),
      .size    (req_size),
      .arr_sel (arr_sel),
      .arr_we  (arr_we),
      .arr_addr(arr_addr),
      .is_tlb  (win_is_tlb),
      .size_err(win_size_err)
   );

   assign arr_wdata = req_wdata;

   assign ctl_err = (req_size != SZ_WORD) || !dec_hit || (req_write && dec_ro);
   assign req_err = req_valid && (req_win ? win_size_err : ctl_err);
   assign reg_wr  = req_valid && req_write && !req_win && !ctl_err;

   mmu_ctl_regfile #(
      .TI_BIT(TI_BIT),
      .ASID_W(ASID_W),
      .AUX_W (AUX_W),
      .EVT_W (EVT_W)
   ) u_regfile (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (reg_wr),
      .wr_idx (dec_idx),
      .wr_data(req_wdata),
      .rd_idx (dec_idx),
      .rd_data(rf_rdata),
      .inval_q(tlb_inval),
      .flush_q(tlb_flush)
   );

   always_comb begin
      rdata_nxt = '0;
      if (req_valid && !req_write && !req_err) begin
         if (req_win) rdata_nxt = win_is_tlb ? arr_rdata : '0;
         else         rdata_nxt = dec_ro ? dec_ro_data : rf_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_err;
         rsp_rdata <= rdata_nxt;
      end
   end

   assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> $past(req_valid));

   assert_err_in_rsp_R11: assert property (@(posedge clk) disable iff (rst)
      rsp_err |-> rsp_valid);

   assert_strobe_needs_word_write_R10: assert property (@(posedge clk) disable iff (rst)
      (tlb_inval || tlb_flush) |->
         $past(req_valid && req_write && !req_win && req_size == SZ_WORD));

   assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
      !(tlb_inval && tlb_flush));
endmodule

// File: tb/mmu_ctl_regs_bench.sv
module mmu_ctl_regs_bench;
   localparam logic [31:0] P_VER = 32'h1234_5678;
   localparam logic [31:0] C_VER = 32'h9ABC_DEF0;
   localparam logic [31:0] P_REV = 32'h0000_00A7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
   logic [26:0] req_addr = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, tlb_inval, tlb_flush, arr_we;
   logic [31:0] rsp_rdata, arr_wdata, arr_rdata;
   logic [3:0]  arr_sel;
   logic [23:0] arr_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mmu_ctl_regs #(
      .PROC_VER(P_VER), .CACHE_VER(C_VER), .PROC_REV(P_REV)
   ) u_mmu_ctl_regs (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .tlb_inval(tlb_inval), .tlb_flush(tlb_flush),
      .arr_sel(arr_sel), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
   );

   // array model: data derived from the selected port and offset
   always_comb begin
      arr_rdata = '0;
      for (int k = 0; k < 4; k++)
         if (arr_sel[k]) arr_rdata = 32'hC000_0000 | (32'(k) << 24) | {8'h0, arr_addr};
   end

   // captured results of the last access
   logic [3:0]  c_sel;
   logic        c_we;
   logic [23:0] c_addr;
   logic [31:0] c_wdata;
   logic        c_vld, c_err, c_inv, c_fl;
   logic [31:0] c_rd;
   logic [31:0] model [9];

   function automatic logic [31:0] mask_of(input int i);
      case (i)
         0:       return 32'hFFFF_FFFB;
         3:       return 32'h0000_000F;
         6, 7, 8: return 32'h0000_07FF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [7:0] off_of(input int i);
      logic [7:0] t [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h24, 8'h28};
      return t[i];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic win, input logic [26:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_win = win;
      req_addr = a; req_size = sz; req_wdata = wd;
      #1;
      c_sel = arr_sel; c_we = arr_we; c_addr = arr_addr; c_wdata = arr_wdata;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      c_vld = rsp_valid; c_err = rsp_err; c_rd = rsp_rdata;
      c_inv = tlb_inval; c_fl = tlb_flush;
   endtask

   task automatic ctl_rd(input logic [7:0] off);
      access(1'b0, 1'b0, {19'h0, off}, 2'd2, 32'h0);
   endtask

   task automatic check_all_regs(input string tag);
      for (int i = 0; i < 9; i++) begin
         ctl_rd(off_of(i));
         check(tag, c_rd, model[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 9; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 rsp_valid", 32'(rsp_valid), 0);
      check("R1 rsp_err", 32'(rsp_err), 0);
      check("R1 strobes", {30'h0, tlb_inval, tlb_flush}, 0);
      check("R1 arr_sel", 32'(arr_sel), 0);
      @(negedge clk); rst = 1'b0;
      check_all_regs("R1 reg reset");

      // R4 R5 R2 mask sweep with several patterns
      for (int p = 0; p < 4; p++) begin
         logic [31:0] pat;
         pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5C3_96EB :
               (p == 2) ? 32'h5A3C_6910 : 32'h0000_0000;
         for (int i = 0; i < 9; i++) begin
            access(1'b1, 1'b0, {19'h0, off_of(i)}, 2'd2, pat ^ (32'(i) << 9));
            check("R11 write rsp", {c_vld, c_err, 30'h0}, 32'h8000_0000);
            check("R11 write rdata", c_rd, 0);
            check("R2 inval", 32'(c_inv), 32'((i == 0) && (pat ^ (32'(i) << 9)) >> 2 & 1));
            check("R3 flush", 32'(c_fl),
                  32'((i == 1) && ((pat ^ (32'(i) << 9)) & 32'hFF) != (model[1] & 32'hFF)));
            model[i] = (pat ^ (32'(i) << 9)) & mask_of(i);
         end
         check_all_regs("R4 R5 R2 readback");
      end

      // R2 TI pulse width, R12
      access(1'b1, 1'b0, 27'h0, 2'd2, 32'h0000_0004);
      check("R2 inval on TI", 32'(c_inv), 1);
      model[0] = 32'h0;
      @(negedge clk);
      check("R12 inval one cycle", 32'(tlb_inval), 0);
      ctl_rd(8'h00);
      check("R2 TI reads 0", c_rd, 0);
      access(1'b1, 1'b0, 27'h0, 2'd2, 32'h8000_0001);
      check("R2 no inval without TI", 32'(c_inv), 0);
      model[0] = 32'h8000_0001;

      // R3 identifier sequence
      begin
         logic [31:0] seq [8] = '{32'h0000_0011, 32'hFFFF_FF11, 32'h0000_0012,
                                  32'h1234_5612, 32'h0000_0000, 32'h0000_0000,
                                  32'hABCD_EF01, 32'h0000_00FF};
         for (int s = 0; s < 8; s++) begin
            access(1'b1, 1'b0, 27'h04, 2'd2, seq[s]);
            check("R3 flush seq", 32'(c_fl), 32'((seq[s] & 32'hFF) != (model[1] & 32'hFF)));
            model[1] = seq[s];
            @(negedge clk);
            check("R12 flush one cycle", 32'(tlb_flush), 0);
         end
         ctl_rd(8'h04);
         check("R3 stored", c_rd, model[1]);
      end

      // R9 sub-word write with a new identifier is rejected
      access(1'b1, 1'b0, 27'h04, 2'd1, 32'h0000_0055);
      check("R9 ctl size err", {31'h0, c_err}, 1);
      check("R9 no flush", 32'(c_fl), 0);
      access(1'b1, 1'b0, 27'h00, 2'd0, 32'hFFFF_FFFF);
      check("R9 no inval", 32'(c_inv), 0);

      // R6 identification registers
      ctl_rd(8'h30); check("R6 proc ver", c_rd, P_VER);
      ctl_rd(8'h40); check("R6 cache ver", c_rd, C_VER);
      ctl_rd(8'h44); check("R6 proc rev", c_rd, P_REV);
      access(1'b1, 1'b0, 27'h30, 2'd2, 32'h0);
      check("R6 write err", {31'h0, c_err}, 1);
      ctl_rd(8'h30); check("R6 unchanged", c_rd, P_VER);

      // R10 unmapped offsets
      begin
         logic [7:0] bad [4] = '{8'h18, 8'h2C, 8'h01, 8'hFC};
         for (int b = 0; b < 4; b++) begin
            access(1'b1, 1'b0, {19'h0, bad[b]}, 2'd2, 32'hDEAD_BEEF);
            check("R10 write err", {31'h0, c_err}, 1);
            check("R10 no strobe", {30'h0, c_inv, c_fl}, 0);
            access(1'b0, 1'b0, {19'h0, bad[b]}, 2'd2, 32'h0);
            check("R10 read err", {c_vld, c_err, 30'h0}, 32'hC000_0000);
            check("R11 err rdata", c_rd, 0);
         end
      end
      check_all_regs("R10 R9 state kept");

      // R7 R8 R9 array window sweep
      for (int r = 0; r < 8; r++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int w = 0; w < 2; w++) begin
               logic [23:0] o;
               logic        tlb, ok;
               logic [3:0]  esel;
               o = 24'h000100 * 24'(r) + 24'h40 * 24'(sz) + 24'h8 * 24'(w) + 24'h3000;
               tlb = (r == 2 || r == 3 || r == 6 || r == 7);
               ok = (sz == 2);
               esel = (tlb && ok) ? (4'b1 << ((r / 4) * 2 + (r % 2))) : 4'b0;
               access(w[0], 1'b1, {3'(r), o}, 2'(sz), 32'h7700_0000 | 32'(o));
               check("R7 R8 sel", 32'(c_sel), 32'(esel));
               check("R7 we", 32'(c_we), 32'(w == 1 && esel != 0));
               if (esel != 0) begin
                  check("R7 addr", 32'(c_addr), 32'(o));
                  check("R7 wdata", c_wdata, 32'h7700_0000 | 32'(o));
               end
               check("R9 win err", {c_vld, c_err, 30'h0}, ok ? 32'h8000_0000 : 32'hC000_0000);
               check("R7 R8 rdata", c_rd, (w == 0 && ok && tlb) ?
                     (32'hC000_0000 | (32'((r / 4) * 2 + (r % 2)) << 24) | 32'(o)) : 32'h0);
            end
         end
      end
      check_all_regs("R8 window leaves regs");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule